// File: doc/BRIEF.md
# Two-Way Lockable Instruction Cache

This block is a read-only, two-way set-associative instruction cache. It sits between a core's fetch port and a slower external memory that answers burst reads. A fetch that hits returns its word combinationally, in the same cycle as the request. A fetch that misses starts a refill of the whole line. The refill asks memory for every word of the line, starting at the line's first word. The word the core asked for goes to the core in the cycle it arrives, and the rest of the line keeps loading behind it.

Each set keeps one replacement bit, which names the least recently used way, and one lock bit per way. Software uses a small command port to pin a resident line so that it is never evicted, to release it again, or to drop it by line address. Dropping a line clears it and writes nothing back. When both ways of a set are pinned, a miss to that set is fetched as a single word straight from memory and nothing is allocated.

Addresses are word addresses. The low `log2(LINE_WORDS)` bits select the word in a line, the next `log2(SETS)` bits select the set, and the remaining upper bits form the tag.

Top module: `icache_lockable`

## Requirements
- R1: On a miss to a set with at least one unlocked way, exactly one memory request is issued, with `mem_single`=0 and `mem_addr` equal to the fetch address with its word-select bits cleared. After the refill, every word of that line hits.
- R2: A fetch that hits while the cache is idle has `fetch_valid`=1 in the same cycle as `fetch_req` and issues no memory request.
- R3: Every word the cache delivers equals the external memory word at `fetch_addr`, whether it comes from a hit, a refill or a single-word fetch.
- R4: Victim choice in a set follows this order: an unlocked way that is not valid, way 0 before way 1; otherwise the unlocked way that was least recently used. A hit or a refill marks its way as most recently used.
- R5: A locked way is never replaced. `ctl_op`=2'b01 locks the way holding `ctl_line`, and `ctl_op`=2'b10 unlocks it. Either command has no effect when the line is not resident.
- R6: `ctl_op`=2'b11 clears the valid and lock state of the way holding `ctl_line` and issues no memory request. The next fetch to that line misses.
- R7: When both ways of the set are locked, a miss issues one request with `mem_single`=1 and `mem_addr`=`fetch_addr`, delivers that word, and allocates nothing, so a repeat fetch misses again.
- R8: During a refill the requested word is delivered in the same cycle its `mem_rvalid` beat arrives, while later words of the line are still outstanding. Any further fetch stalls until the refill has finished. Memory returns burst words in ascending address order, one word per `mem_rvalid` cycle.
- R9: `fetch_stall` is high exactly when `fetch_req` is high and `fetch_valid` is low.
- R10: A control command takes effect only in a cycle where no refill or single-word fetch is in progress and `fetch_stall` is low. At other times it is ignored.
- R11: After reset every line is invalid and unlocked, and `fetch_valid`, `fetch_stall` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | input | 1 | Core fetch request; held with its address until `fetch_valid` |
| fetch_addr | input | ADDR_W | Word address of the fetch |
| fetch_valid | output | 1 | Delivered word is present this cycle |
| fetch_data | output | DATA_W | Delivered instruction word |
| fetch_stall | output | 1 | Request pending, no data yet |
| mem_req | output | 1 | One-cycle read request pulse to external memory |
| mem_addr | output | ADDR_W | First word address of the read |
| mem_single | output | 1 | 1: one-word read, 0: full-line burst |
| mem_rvalid | input | 1 | A read word is present |
| mem_rdata | input | DATA_W | Read word, ascending order |
| ctl_valid | input | 1 | Control command strobe |
| ctl_op | input | 2 | 01 lock, 10 unlock, 11 invalidate, 00 none |
| ctl_line | input | ADDR_W-log2(LINE_WORDS) | Line address (set and tag) the command names |

## Verification
The embedded properties check, on every cycle, that the memory request is a single-cycle pulse and that a burst address is line-aligned. They also check that a single-word request only follows a miss to a fully locked set, that a refill never lands in a locked way, and that an idle hit never produces a memory request. Which line the replacement order evicts, whether locks survive competing misses, and whether invalidation and ignored commands leave the right lines resident can only be seen across sequences of fetches. The bench shows these with a reference model of tags, valid bits, locks and replacement bits. Early delivery before the burst ends, and the stall of a fetch that follows it, are shown by directed scenarios against a memory responder that inserts random gaps between beats.

// File: rtl/icache_pkg.sv
package icache_pkg;
   typedef enum logic [1:0] {
      CTL_NOP    = 2'b00,
      CTL_LOCK   = 2'b01,
      CTL_UNLOCK = 2'b10,
      CTL_INVAL  = 2'b11
   } ctl_op_e;

   typedef enum logic [1:0] {
      SQ_IDLE   = 2'b00,
      SQ_FILL   = 2'b01,
      SQ_BYPASS = 2'b10
   } seq_state_e;
endpackage

// File: rtl/icache_tag_store.sv
module icache_tag_store
   import icache_pkg::*;
#(
   parameter int LINE_W = 13,
   parameter int SETS   = 16,
   localparam int SET_W = $clog2(SETS),
   localparam int TAG_W = LINE_W - SET_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LINE_W-1:0] lk_line,
   output logic              hit,
   output logic              hit_way,
   output logic              victim_way,
   output logic              all_locked,
   input  logic              touch,
   input  logic              ctl_apply,
   input  ctl_op_e           ctl_op,
   input  logic [LINE_W-1:0] ctl_line,
   input  logic              fill_done,
   input  logic              fill_way,
   input  logic [LINE_W-1:0] fill_line
);
   logic [TAG_W-1:0] tag_q   [SETS][2];
   logic [1:0]       valid_q [SETS];
   logic [1:0]       lock_q  [SETS];
   logic [SETS-1:0]  lru_q;

   logic [SET_W-1:0] lk_set, c_set, f_set;
   logic [TAG_W-1:0] lk_tag, c_tag, f_tag;
   logic [1:0]       lk_match, c_match;

   assign lk_set = lk_line[SET_W-1:0];
   assign lk_tag = lk_line[LINE_W-1:SET_W];
   assign c_set  = ctl_line[SET_W-1:0];
   assign c_tag  = ctl_line[LINE_W-1:SET_W];
   assign f_set  = fill_line[SET_W-1:0];
   assign f_tag  = fill_line[LINE_W-1:SET_W];

   for (genvar w = 0; w < 2; w++) begin : g_cmp
      assign lk_match[w] = valid_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
      assign c_match[w]  = valid_q[c_set][w]  && (tag_q[c_set][w]  == c_tag);
   end

   assign hit     = |lk_match;
   assign hit_way = lk_match[1];

   always_comb begin
      all_locked = &lock_q[lk_set];
      if (lock_q[lk_set][0])       victim_way = 1'b1;
      else if (lock_q[lk_set][1])  victim_way = 1'b0;
      else if (!valid_q[lk_set][0]) victim_way = 1'b0;
      else if (!valid_q[lk_set][1]) victim_way = 1'b1;
      else                          victim_way = lru_q[lk_set];
   end

   always_ff @(posedge clk) begin
      if (fill_done) tag_q[f_set][fill_way] <= f_tag;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            valid_q[s] <= '0;
            lock_q[s]  <= '0;
         end
         lru_q <= '0;
      end else begin
         if (touch) lru_q[lk_set] <= ~hit_way;
         if (fill_done) begin
            valid_q[f_set][fill_way] <= 1'b1;
            lru_q[f_set]             <= ~fill_way;
         end
         if (ctl_apply) begin
            case (ctl_op)
               CTL_LOCK:   lock_q[c_set] <= lock_q[c_set] | c_match;
               CTL_UNLOCK: lock_q[c_set] <= lock_q[c_set] & ~c_match;
               CTL_INVAL: begin
                  valid_q[c_set] <= valid_q[c_set] & ~c_match;
                  lock_q[c_set]  <= lock_q[c_set] & ~c_match;
               end
               default: ;
            endcase
         end
      end
   end

   // R5: a refill must never overwrite a pinned way
   a_r5_no_locked_victim: assert property (@(posedge clk) disable iff (!rst_n)
      fill_done |-> !lock_q[f_set][fill_way]);
endmodule

// File: rtl/icache_data_store.sv
module icache_data_store #(
   parameter int IDX_W  = 7,
   parameter int DATA_W = 32,
   localparam int DEPTH = 2 ** IDX_W
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic              wr_way,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_way,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] rd_word [2];

   for (genvar w = 0; w < 2; w++) begin : g_way
      logic [DATA_W-1:0] bank_q [DEPTH];
      always_ff @(posedge clk) begin
         if (wr_en && (wr_way == 1'(w))) bank_q[wr_idx] <= wr_data;
      end
      assign rd_word[w] = bank_q[rd_idx];
   end

   assign rd_data = rd_word[rd_way];
endmodule

// File: rtl/icache_fill_seq.sv
module icache_fill_seq
   import icache_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int OFF_W  = 3,
   localparam int LINE_W = ADDR_W - OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_req,
   input  logic [ADDR_W-1:0] fetch_addr,
   input  logic              hit,
   input  logic              victim_way,
   input  logic              all_locked,
   input  logic              mem_rvalid,
   output logic              idle,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_single,
   output logic              crit_valid,
   output logic              wr_en,
   output logic              wr_way,
   output logic [OFF_W-1:0]  wr_off,
   output logic              fill_done,
   output logic [LINE_W-1:0] fill_line
);
   localparam logic [OFF_W-1:0] LAST = '1;

   seq_state_e        state_q;
   logic [ADDR_W-1:0] cap_q;
   logic              way_q;
   logic [OFF_W-1:0]  cnt_q;
   logic              req_q, single_q;
   logic [ADDR_W-1:0] addr_q;
   logic              start;

   assign idle  = (state_q == SQ_IDLE);
   assign start = idle && fetch_req && !hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= SQ_IDLE;
         cap_q    <= '0;
         way_q    <= 1'b0;
         cnt_q    <= '0;
         req_q    <= 1'b0;
         single_q <= 1'b0;
         addr_q   <= '0;
      end else begin
         req_q <= 1'b0;
         case (state_q)
            SQ_IDLE: if (start) begin
               cap_q    <= fetch_addr;
               way_q    <= victim_way;
               cnt_q    <= '0;
               req_q    <= 1'b1;
               single_q <= all_locked;
               addr_q   <= all_locked ? fetch_addr
                                      : {fetch_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
               state_q  <= all_locked ? SQ_BYPASS : SQ_FILL;
            end
            SQ_FILL: if (mem_rvalid) begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == LAST) state_q <= SQ_IDLE;
            end
            SQ_BYPASS: if (mem_rvalid) state_q <= SQ_IDLE;
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign mem_req    = req_q;
   assign mem_addr   = addr_q;
   assign mem_single = single_q;
   assign wr_en      = (state_q == SQ_FILL) && mem_rvalid;
   assign wr_way     = way_q;
   assign wr_off     = cnt_q;
   assign fill_done  = wr_en && (cnt_q == LAST);
   assign fill_line  = cap_q[ADDR_W-1:OFF_W];
   assign crit_valid = mem_rvalid &&
                       (((state_q == SQ_FILL) && (cnt_q == cap_q[OFF_W-1:0])) ||
                        (state_q == SQ_BYPASS));

   // R1: the read request is a single-cycle pulse
   a_r1_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);
   // R1: a line burst always starts on the first word of the line
   a_r1_burst_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_single) |-> (mem_addr[OFF_W-1:0] == '0));
   // R7: a one-word read only follows a miss to a fully pinned set
   a_r7_single_needs_locks: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_single) |-> $past(all_locked));
endmodule

// File: rtl/icache_lockable.sv
module icache_lockable
   import icache_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 32,
   parameter int LINE_WORDS = 8,
   parameter int SETS       = 16,
   localparam int OFF_W  = $clog2(LINE_WORDS),
   localparam int SET_W  = $clog2(SETS),
   localparam int LINE_W = ADDR_W - OFF_W,
   localparam int IDX_W  = SET_W + OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_req,
   input  logic [ADDR_W-1:0] fetch_addr,
   output logic              fetch_valid,
   output logic [DATA_W-1:0] fetch_data,
   output logic              fetch_stall,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_single,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              ctl_valid,
   input  logic [1:0]        ctl_op,
   input  logic [LINE_W-1:0] ctl_line
);
   if (LINE_WORDS < 2 || (2 ** OFF_W) != LINE_WORDS) begin : g_bad_line
      $error("LINE_WORDS must be a power of two, at least 2");
   end
   if (SETS < 2 || (2 ** SET_W) != SETS) begin : g_bad_sets
      $error("SETS must be a power of two, at least 2");
   end
   if (ADDR_W <= IDX_W) begin : g_bad_addr
      $error("ADDR_W leaves no tag bits");
   end

   logic              hit, hit_way, victim_way, all_locked;
   logic              seq_idle, crit_valid, wr_en, wr_way, fill_done;
   logic [OFF_W-1:0]  wr_off;
   logic [LINE_W-1:0] fill_line;
   logic [DATA_W-1:0] rd_data;
   logic              idle_hit, ctl_apply;

   assign idle_hit    = seq_idle && fetch_req && hit;
   assign fetch_valid = idle_hit || crit_valid;
   assign fetch_data  = crit_valid ? mem_rdata : rd_data;
   assign fetch_stall = fetch_req && !fetch_valid;
   assign ctl_apply   = ctl_valid && seq_idle && !fetch_stall;

   icache_tag_store #(.LINE_W(LINE_W), .SETS(SETS)) u_tags (
      .clk        (clk),
      .rst_n      (rst_n),
      .lk_line    (fetch_addr[ADDR_W-1:OFF_W]),
      .hit        (hit),
      .hit_way    (hit_way),
      .victim_way (victim_way),
      .all_locked (all_locked),
      .touch      (idle_hit),
      .ctl_apply  (ctl_apply),
      .ctl_op     (ctl_op_e'(ctl_op)),
      .ctl_line   (ctl_line),
      .fill_done  (fill_done),
      .fill_way   (wr_way),
      .fill_line  (fill_line)
   );

   icache_data_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_data (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_way  (wr_way),
      .wr_idx  ({fill_line[SET_W-1:0], wr_off}),
      .wr_data (mem_rdata),
      .rd_way  (hit_way),
      .rd_idx  (fetch_addr[IDX_W-1:0]),
      .rd_data (rd_data)
   );

   icache_fill_seq #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .fetch_req  (fetch_req),
      .fetch_addr (fetch_addr),
      .hit        (hit),
      .victim_way (victim_way),
      .all_locked (all_locked),
      .mem_rvalid (mem_rvalid),
      .idle       (seq_idle),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr),
      .mem_single (mem_single),
      .crit_valid (crit_valid),
      .wr_en      (wr_en),
      .wr_way     (wr_way),
      .wr_off     (wr_off),
      .fill_done  (fill_done),
      .fill_line  (fill_line)
   );

   // R2: an idle hit never leads to an external read
   a_r2_hit_no_read: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_idle && fetch_req && fetch_valid) |=> !mem_req);
   // R9: data is only presented against a live request
   a_r9_valid_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_valid |-> fetch_req);
endmodule

// File: tb/icache_lockable_bench.sv
`timescale 1ns/1ps
module icache_lockable_bench;
   localparam int AW = 16;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          fetch_req = 1'b0;
   logic [AW-1:0] fetch_addr = '0;
   logic          fetch_valid, fetch_stall, mem_req, mem_single;
   logic [DW-1:0] fetch_data;
   logic [AW-1:0] mem_addr;
   logic          mem_rvalid;
   logic [DW-1:0] mem_rdata;
   logic          ctl_valid = 1'b0;
   logic [1:0]    ctl_op = 2'b00;
   logic [12:0]   ctl_line = '0;

   icache_lockable u_icache_lockable (
      .clk(clk), .rst_n(rst_n),
      .fetch_req(fetch_req), .fetch_addr(fetch_addr),
      .fetch_valid(fetch_valid), .fetch_data(fetch_data), .fetch_stall(fetch_stall),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_single(mem_single),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .ctl_valid(ctl_valid), .ctl_op(ctl_op), .ctl_line(ctl_line)
   );

   always #2.5 clk = ~clk;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   function automatic logic [DW-1:0] mword(input logic [AW-1:0] a);
      return {a, a ^ 16'h3C5A};
   endfunction

   function automatic logic [AW-1:0] mk(input int tg, input int st, input int off);
      return AW'((tg << 7) | (st << 3) | off);
   endfunction

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   // memory responder
   bit            mbusy = 0;
   logic [AW-1:0] mbase;
   int            mlen, midx, mdelay, req_cnt = 0;
   logic [AW-1:0] last_addr;
   bit            last_single;

   initial begin
      mem_rvalid = 1'b0;
      mem_rdata  = '0;
      forever begin
         @(negedge clk);
         mem_rvalid = 1'b0;
         if (mbusy) begin
            if (mdelay > 0) mdelay--;
            else if (($urandom % 4) != 0) begin
               mem_rvalid = 1'b1;
               mem_rdata  = mword(mbase + AW'(midx));
               midx++;
               if (midx == mlen) mbusy = 0;
            end
         end
         if (mem_req) begin
            req_cnt++;
            last_addr   = mem_addr;
            last_single = mem_single;
            mbusy  = 1;
            mbase  = mem_addr;
            mlen   = mem_single ? 1 : 8;
            midx   = 0;
            mdelay = 1;
         end
      end
   end

   // reference model of tag, valid, lock and replacement state
   bit mv [16][2];
   int mt [16][2];
   bit ml [16][2];
   bit mlru [16];

   function automatic int m_way(input logic [AW-1:0] a);
      int st, tg;
      st = int'(a[6:3]);
      tg = int'(a[15:7]);
      if (mv[st][0] && mt[st][0] == tg) return 0;
      if (mv[st][1] && mt[st][1] == tg) return 1;
      return -1;
   endfunction

   function automatic void m_update(input logic [AW-1:0] a);
      int st, w, v;
      st = int'(a[6:3]);
      w  = m_way(a);
      if (w >= 0) mlru[st] = (w == 0);
      else if (!(ml[st][0] && ml[st][1])) begin
         if (ml[st][0])       v = 1;
         else if (ml[st][1])  v = 0;
         else if (!mv[st][0]) v = 0;
         else if (!mv[st][1]) v = 1;
         else                 v = int'(mlru[st]);
         mv[st][v] = 1;
         mt[st][v] = int'(a[15:7]);
         mlru[st]  = (v == 0);
      end
   endfunction

   function automatic void m_ctl(input logic [1:0] op, input logic [AW-1:0] a);
      int st, w;
      st = int'(a[6:3]);
      w  = m_way(a);
      if (w >= 0) begin
         if (op == 2'b01) ml[st][w] = 1;
         if (op == 2'b10) ml[st][w] = 0;
         if (op == 2'b11) begin mv[st][w] = 0; ml[st][w] = 0; end
      end
   endfunction

   task automatic wait_idle();
      while (mbusy) begin @(negedge clk); #1; end
      @(negedge clk); #1;
   endtask

   task automatic fetch_check(input logic [AW-1:0] a, input string rq);
      bit eh, es;
      int cyc, n0;
      logic [DW-1:0] got;
      eh = (m_way(a) >= 0);
      es = !eh && ml[int'(a[6:3])][0] && ml[int'(a[6:3])][1];
      wait_idle();
      n0 = req_cnt;
      @(negedge clk);
      fetch_req  = 1'b1;
      fetch_addr = a;
      #1;
      chk(fetch_stall == !fetch_valid, "R9", "stall vs valid", 32'(fetch_stall), 32'(!fetch_valid));
      cyc = 0;
      while (!fetch_valid && cyc < 400) begin @(negedge clk); #1; cyc++; end
      got = fetch_data;
      @(negedge clk);
      fetch_req = 1'b0;
      wait_idle();
      chk(got == mword(a), "R3", "fetched word", got, mword(a));
      chk((cyc == 0) == eh, rq, "hit in request cycle", 32'(cyc == 0), 32'(eh));
      chk((req_cnt - n0) == (eh ? 0 : 1), eh ? "R2" : "R1", "memory requests",
          32'(req_cnt - n0), eh ? 32'd0 : 32'd1);
      if (!eh) begin
         chk(last_single == es, "R7", "single-word flag", 32'(last_single), 32'(es));
         if (es) chk(last_addr == a, "R7", "single address", 32'(last_addr), 32'(a));
         else chk(last_addr == {a[15:3], 3'b000}, "R1", "burst address",
                  32'(last_addr), 32'({a[15:3], 3'b000}));
      end
      m_update(a);
   endtask

   task automatic ctl_cmd(input logic [1:0] op, input logic [AW-1:0] a);
      int n0;
      wait_idle();
      n0 = req_cnt;
      @(negedge clk);
      ctl_valid = 1'b1; ctl_op = op; ctl_line = a[15:3];
      @(negedge clk);
      ctl_valid = 1'b0;
      #1;
      chk(req_cnt == n0, "R6", "no request from command", 32'(req_cnt), 32'(n0));
      m_ctl(op, a);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual=expired expected=finished");
         $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad);
         $finish;
      end
   end

   initial begin
      int cyc, n0;
      void'($urandom(32'd4242));
      for (int s = 0; s < 16; s++)
         for (int w = 0; w < 2; w++) begin mv[s][w] = 0; ml[s][w] = 0; mt[s][w] = 0; end
      for (int s = 0; s < 16; s++) mlru[s] = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      // R11: quiet outputs after reset
      chk(!fetch_valid && !fetch_stall && !mem_req, "R11", "reset outputs",
          {29'd0, fetch_valid, fetch_stall, mem_req}, 32'd0);

      // R1: cold miss fills the whole line, other words then hit
      fetch_check(mk(1, 8, 0), "R11");
      fetch_check(mk(1, 8, 6), "R1");
      fetch_check(mk(1, 8, 3), "R1");

      // R8: early delivery, then a follow-on fetch stalls behind the refill
      wait_idle();
      n0 = req_cnt;
      @(negedge clk); fetch_req = 1'b1; fetch_addr = mk(2, 9, 5); #1;
      cyc = 0;
      while (!fetch_valid && cyc < 400) begin @(negedge clk); #1; cyc++; end
      chk(mbusy && midx == 6, "R8", "words received at delivery", 32'(midx), 32'd6);
      chk(fetch_data == mword(mk(2, 9, 5)), "R8", "early word", fetch_data, mword(mk(2, 9, 5)));
      @(negedge clk); fetch_addr = mk(2, 9, 7); #1;
      chk(fetch_stall == 1'b1, "R8", "stall during background refill", 32'(fetch_stall), 32'd1);
      cyc = 0;
      while (!fetch_valid && cyc < 400) begin @(negedge clk); #1; cyc++; end
      chk(fetch_data == mword(mk(2, 9, 7)), "R8", "word after refill", fetch_data, mword(mk(2, 9, 7)));
      chk(!mbusy, "R8", "second word only after burst end", 32'(mbusy), 32'd0);
      @(negedge clk); fetch_req = 1'b0;
      wait_idle();
      chk(req_cnt - n0 == 1, "R8", "one burst for both fetches", 32'(req_cnt - n0), 32'd1);
      m_update(mk(2, 9, 5)); m_update(mk(2, 9, 7));

      // R4: replacement order in set 10
      fetch_check(mk(0, 10, 1), "R4");
      fetch_check(mk(1, 10, 2), "R4");
      fetch_check(mk(0, 10, 3), "R4");
      fetch_check(mk(2, 10, 4), "R4");   // evicts tag 1
      fetch_check(mk(0, 10, 5), "R4");
      fetch_check(mk(1, 10, 6), "R4");   // misses

      // R5: a pinned line survives even when least recently used
      fetch_check(mk(0, 11, 0), "R5");
      fetch_check(mk(1, 11, 0), "R5");
      ctl_cmd(2'b01, mk(0, 11, 0));
      ctl_cmd(2'b01, mk(3, 11, 0));      // not resident: no effect
      fetch_check(mk(1, 11, 1), "R5");
      fetch_check(mk(2, 11, 1), "R5");
      fetch_check(mk(0, 11, 2), "R5");
      fetch_check(mk(3, 11, 2), "R5");
      fetch_check(mk(0, 11, 4), "R5");
      ctl_cmd(2'b10, mk(0, 11, 0));
      fetch_check(mk(2, 11, 5), "R5");
      fetch_check(mk(1, 11, 5), "R5");

      // R6: invalidate drops a line
      fetch_check(mk(1, 11, 6), "R6");
      ctl_cmd(2'b11, mk(1, 11, 0));
      fetch_check(mk(1, 11, 7), "R6");

      // R7: both ways pinned
      fetch_check(mk(0, 12, 0), "R7");
      fetch_check(mk(1, 12, 0), "R7");
      ctl_cmd(2'b01, mk(0, 12, 0));
      ctl_cmd(2'b01, mk(1, 12, 0));
      fetch_check(mk(2, 12, 3), "R7");
      fetch_check(mk(2, 12, 3), "R7");
      fetch_check(mk(0, 12, 7), "R7");
      fetch_check(mk(1, 12, 7), "R7");

      // R10: command during a refill is ignored
      fetch_check(mk(0, 13, 2), "R10");
      wait_idle();
      @(negedge clk); fetch_req = 1'b1; fetch_addr = mk(0, 14, 7); #1;
      while (!mbusy) begin @(negedge clk); #1; end
      ctl_valid = 1'b1; ctl_op = 2'b11; ctl_line = mk(0, 13, 0) >> 3;
      @(negedge clk); ctl_valid = 1'b0; #1;
      cyc = 0;
      while (!fetch_valid && cyc < 400) begin @(negedge clk); #1; cyc++; end
      chk(fetch_data == mword(mk(0, 14, 7)), "R3", "word during ignored command",
          fetch_data, mword(mk(0, 14, 7)));
      @(negedge clk); fetch_req = 1'b0;
      m_update(mk(0, 14, 7));
      fetch_check(mk(0, 13, 5), "R10");

      // random mix
      for (int i = 0; i < 300; i++) begin
         logic [AW-1:0] a;
         a = mk(int'($urandom % 3), int'($urandom % 4), int'($urandom % 8));
         if (($urandom % 7) == 0) ctl_cmd(2'(1 + ($urandom % 3)), a);
         else fetch_check(a, (m_way(a) >= 0) ? "R2" : "R4");
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule